// File: doc/BRIEF.md
# Descriptor-Chained Audio Stream Mover

This block moves one audio stream between a codec-facing byte port and system memory. The memory side is described by a list of buffer descriptors. When software sets the run bit, the engine fetches the list into a small local table. After that, every transfer request from the codec side is split into memory bursts. A burst never runs past the end of the current descriptor, nor past the end of the cyclic buffer. The engine tracks two positions: a link position, which is the byte offset inside the cyclic buffer, and a current descriptor index. Both wrap around.

A descriptor can ask for an interrupt when it is fully consumed. In that case the engine sets a sticky completion bit in its control word, and that bit drives the interrupt line. An optional position buffer can be enabled. When it is, the engine writes the link position to memory after each finished request, so software can poll it.

Each instance is parameterised with its stream index. Indices in the lower half of the stream range are capture streams, which write memory. Indices in the upper half are playback streams, which read memory.

Top module: `sdma_stream_engine`

## Requirements
- R1: Reset state:
  - the control word reads 0x2000_0000 (only bit 29, the FIFO-ready status, set);
  - the link position and descriptor index are 0;
  - no memory request is raised;
  - `xfer_ready` is 1 and `irq` is 0.
- R2: Descriptor fetch on start:
  - A write that takes control bit 1 (run) from 0 to 1 fetches min(`lvi`, MAX_DESC-1)+1 descriptors. Each fetch is a request of kind 0, length 16, at `bdl_base` + 16·i, in order.
  - The returned descriptor has its address in `mem_rdata[63:0]`, its length in `[95:64]` and its interrupt flag in bit 96.
  - Starting resets the link position, the descriptor index and the in-descriptor offset to 0.
- R3: A transfer request is taken only when all of these hold: the list is loaded, the stream is running, `xfer_tag` equals control bits 23:20, and `xfer_out` equals the stream direction (1 when STREAM_IDX ≥ NUM_STREAMS/2). Any other request gets a one-cycle `xfer_err` and causes no memory traffic.
- R4: Burst sizing and direction:
  - Each data burst (kind 1) has length = min(bytes left, cyclic length − link position, descriptor length − in-descriptor offset).
  - It is addressed at descriptor address + in-descriptor offset.
  - `mem_we` is 1 for capture streams and 0 for playback streams.
- R5: The link position advances by each burst length and becomes 0 on reaching `cbl`.
- R6: When a descriptor is fully consumed the index advances; after the last entry it returns to 0.
- R7: Fully consuming a descriptor whose interrupt flag is set sets control bit 26. `irq` is control bit 26 AND control bit 2 (interrupt enable).
- R8: Control bits 28:26 are cleared by writing 1 to them. An engine set of bit 26 in the same cycle wins over the clear.
- R9: Position buffer:
  - When `pos_base` bit 0 is 1, each finished request ends with a kind-2 write of the link position to (`pos_base` with bit 0 cleared) + 8·STREAM_IDX.
  - When bit 0 is 0, no such write is made.
- R10: Writing control bit 0 (stream reset) leaves the control word at 0x2000_0000 and returns the engine to idle.
- R11: Every accepted request ends with exactly one `xfer_done` pulse. A zero-byte request issues no data bursts.
- R12: After the run bit is cleared, or before it is ever set, every request is refused with `xfer_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_data | input | 32 | Control word write value |
| ctl_word | output | 32 | Current control/status word |
| cbl | input | 32 | Cyclic buffer length in bytes |
| lvi | input | 8 | Last valid descriptor index |
| bdl_base | input | 64 | Descriptor list base address |
| pos_base | input | 64 | Position buffer base; bit 0 enables |
| xfer_valid | input | 1 | Transfer request strobe |
| xfer_ready | output | 1 | Engine can take a request |
| xfer_tag | input | 4 | Stream tag of the request |
| xfer_out | input | 1 | Request direction, 1 = playback |
| xfer_bytes | input | 16 | Requested byte count |
| xfer_done | output | 1 | Request finished |
| xfer_err | output | 1 | Request refused |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_kind | output | 2 | 0 descriptor, 1 data, 2 position |
| mem_addr | output | 64 | Memory byte address |
| mem_len | output | 32 | Memory byte count |
| mem_wdata | output | 32 | Position write data |
| mem_ack | input | 1 | Memory request completed |
| mem_rdata | input | 128 | Descriptor read data |
| link_pos | output | 32 | Link position in the cyclic buffer |
| entry_idx | output | 3 | Current descriptor index |
| irq | output | 1 | Completion interrupt |

## Verification
The request sequence is chosen so that requests land on every combination of the burst-length limits. One request crosses a descriptor boundary. Another hits the end of the cyclic buffer, where the link position and the descriptor index both wrap. A design that ignored either limit would issue bursts that are too long. A design that wrapped only one counter would resume at the wrong address.

A completion flag on the middle descriptor shows whether the sticky bit is set exactly once per flagged descriptor. The bench also probes the refusal paths (wrong tag, wrong direction, not running, after stream reset), the enable bit of the position buffer, and the reload of the list on a second start. A design that lost its positions on reload would show them there.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WAIT,
        ST_MOVE,
        ST_POSN,
        ST_RESP
    } eng_state_e;

    localparam int CB_RST  = 0;
    localparam int CB_RUN  = 1;
    localparam int CB_IEN  = 2;
    localparam int CB_CMP  = 26;
    localparam int CB_TAGL = 20;

    localparam logic [31:0] CTL_FIFO_RDY = 32'h2000_0000;
    localparam logic [31:0] CTL_WMASK    = 32'h00F0_0006;
    localparam logic [31:0] CTL_W1C      = 32'h1C00_0000;

    localparam logic [1:0] MK_DESC = 2'd0;
    localparam logic [1:0] MK_DATA = 2'd1;
    localparam logic [1:0] MK_POS  = 2'd2;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] len;
        logic        ioc;
    } desc_t;

endpackage

// File: rtl/sdma_ctl_word.sv
module sdma_ctl_word
    import sdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        cmp_set,
    output logic [31:0] ctl_q,
    output logic        run_rise,
    output logic        strm_rst
);

    logic [31:0] ctl_d;

    assign strm_rst = wr_en && wr_data[CB_RST];
    assign run_rise = wr_en && !wr_data[CB_RST] && wr_data[CB_RUN] && !ctl_q[CB_RUN];

    always_comb begin
        ctl_d = ctl_q;
        if (strm_rst) begin
            ctl_d = CTL_FIFO_RDY;
        end else begin
            if (wr_en) begin
                ctl_d = (ctl_q & ~CTL_WMASK) | (wr_data & CTL_WMASK);
                ctl_d = ctl_d & ~(wr_data & CTL_W1C);
            end
            if (cmp_set) begin
                ctl_d[CB_CMP] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_FIFO_RDY;
        else        ctl_q <= ctl_d;
    end

    assert_reset_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[CB_RST]) |=> (ctl_q == CTL_FIFO_RDY));

    assert_cmp_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_set && !(wr_en && wr_data[CB_RST])) |=> ctl_q[CB_CMP]);

    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[CB_CMP] && !cmp_set) |=> !ctl_q[CB_CMP]);

endmodule

// File: rtl/sdma_desc_tbl.sv
module sdma_desc_tbl
    import sdma_pkg::*;
#(
    parameter int MAX_DESC = 8,
    parameter int IDXW     = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IDXW-1:0] widx,
    input  desc_t           wdesc,
    input  logic [IDXW-1:0] ridx,
    output desc_t           rdesc
);

    desc_t rows [MAX_DESC];

    for (genvar g = 0; g < MAX_DESC; g++) begin : g_ent
        desc_t ent_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          ent_q <= '0;
            else if (we && widx == IDXW'(g))     ent_q <= wdesc;
        end
        assign rows[g] = ent_q;
    end

    assign rdesc = rows[ridx];

endmodule

// File: rtl/sdma_chunk.sv
module sdma_chunk (
    input  logic [31:0] left,
    input  logic [31:0] ring_len,
    input  logic [31:0] ring_pos,
    input  logic [31:0] desc_len,
    input  logic [31:0] desc_ofs,
    output logic [31:0] chunk
);

    logic [31:0] ring_room;
    logic [31:0] desc_room;
    logic [31:0] m1;

    always_comb begin
        ring_room = ring_len - ring_pos;
        desc_room = desc_len - desc_ofs;
        m1        = (left < ring_room) ? left : ring_room;
        chunk     = (m1 < desc_room) ? m1 : desc_room;
    end

endmodule

// File: rtl/sdma_stream_engine.sv
module sdma_stream_engine
    import sdma_pkg::*;
#(
    parameter int NUM_STREAMS = 8,
    parameter int STREAM_IDX  = 5,
    parameter int MAX_DESC    = 8,
    parameter int REQW        = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctl_wr_en,
    input  logic [31:0]  ctl_wr_data,
    output logic [31:0]  ctl_word,
    input  logic [31:0]  cbl,
    input  logic [7:0]   lvi,
    input  logic [63:0]  bdl_base,
    input  logic [63:0]  pos_base,
    input  logic         xfer_valid,
    output logic         xfer_ready,
    input  logic [3:0]   xfer_tag,
    input  logic         xfer_out,
    input  logic [REQW-1:0] xfer_bytes,
    output logic         xfer_done,
    output logic         xfer_err,
    output logic         mem_req,
    output logic         mem_we,
    output logic [1:0]   mem_kind,
    output logic [63:0]  mem_addr,
    output logic [31:0]  mem_len,
    output logic [31:0]  mem_wdata,
    input  logic         mem_ack,
    input  logic [127:0] mem_rdata,
    output logic [31:0]  link_pos,
    output logic [$clog2(MAX_DESC)-1:0] entry_idx,
    output logic         irq
);

    localparam int          IDXW    = (MAX_DESC > 1) ? $clog2(MAX_DESC) : 1;
    localparam logic        IS_OUT  = (STREAM_IDX >= NUM_STREAMS / 2);
    localparam logic [63:0] POS_OFS = 64'(STREAM_IDX * 8);

    typedef struct packed {
        eng_state_e      st;
        logic [IDXW-1:0] lidx;
        logic [IDXW-1:0] last;
        logic [IDXW-1:0] be;
        logic [31:0]     bp;
        logic [31:0]     lpib;
        logic [31:0]     left;
        logic            done;
        logic            err;
    } eng_t;

    eng_t q, nx;

    logic            cmp_set, run_rise, strm_rst, tbl_we, accept, tag_ok, run;
    logic [IDXW-1:0] last_in;
    logic [31:0]     chunk;
    desc_t           cur, fetched;
    logic            unused_bits;

    assign unused_bits = ^{mem_rdata[127:97], lvi, pos_base[63:1]};

    sdma_ctl_word u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr_en), .wr_data(ctl_wr_data),
        .cmp_set(cmp_set), .ctl_q(ctl_word), .run_rise(run_rise), .strm_rst(strm_rst)
    );

    assign fetched = '{addr: mem_rdata[63:0], len: mem_rdata[95:64], ioc: mem_rdata[96]};

    sdma_desc_tbl #(.MAX_DESC(MAX_DESC), .IDXW(IDXW)) u_tbl (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(q.lidx), .wdesc(fetched),
        .ridx(q.be), .rdesc(cur)
    );

    sdma_chunk u_chunk (
        .left(q.left), .ring_len(cbl), .ring_pos(q.lpib),
        .desc_len(cur.len), .desc_ofs(q.bp), .chunk(chunk)
    );

    assign last_in    = (lvi >= 8'(MAX_DESC)) ? IDXW'(MAX_DESC - 1) : lvi[IDXW-1:0];
    assign run        = ctl_word[CB_RUN];
    assign xfer_ready = (q.st == ST_IDLE) || (q.st == ST_WAIT);
    assign accept     = xfer_valid && xfer_ready;
    assign tag_ok     = (xfer_tag == ctl_word[CB_TAGL+3:CB_TAGL]) && (xfer_out == IS_OUT) && run;

    always_comb begin
        nx      = q;
        nx.done = 1'b0;
        nx.err  = 1'b0;
        cmp_set = 1'b0;
        tbl_we  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (accept) nx.err = 1'b1;
            end
            ST_LOAD: begin
                if (!run) begin
                    nx.st = ST_IDLE;
                end else if (mem_ack) begin
                    tbl_we = 1'b1;
                    if (q.lidx == q.last) nx.st = ST_WAIT;
                    else                  nx.lidx = q.lidx + 1'b1;
                end
            end
            ST_WAIT: begin
                if (accept) begin
                    if (tag_ok) begin
                        nx.left = 32'(xfer_bytes);
                        nx.st   = ST_MOVE;
                    end else begin
                        nx.err = 1'b1;
                    end
                end else if (!run) begin
                    nx.st = ST_IDLE;
                end
            end
            ST_MOVE: begin
                if (q.left == 32'd0) begin
                    nx.st = pos_base[0] ? ST_POSN : ST_RESP;
                end else if (chunk == 32'd0) begin
                    nx.bp = 32'd0;
                    nx.be = (q.be == q.last) ? '0 : q.be + 1'b1;
                end else if (mem_ack) begin
                    nx.left = q.left - chunk;
                    nx.lpib = (q.lpib + chunk == cbl) ? 32'd0 : q.lpib + chunk;
                    if (q.bp + chunk == cur.len) begin
                        cmp_set = cur.ioc;
                        nx.bp   = 32'd0;
                        nx.be   = (q.be == q.last) ? '0 : q.be + 1'b1;
                    end else begin
                        nx.bp = q.bp + chunk;
                    end
                end
            end
            ST_POSN: begin
                if (mem_ack) nx.st = ST_RESP;
            end
            ST_RESP: begin
                nx.done = 1'b1;
                nx.st   = ST_WAIT;
            end
            default: nx.st = ST_IDLE;
        endcase
        if (run_rise) begin
            nx.st   = ST_LOAD;
            nx.lidx = '0;
            nx.be   = '0;
            nx.bp   = 32'd0;
            nx.lpib = 32'd0;
            nx.last = last_in;
        end
        if (strm_rst) nx.st = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= nx;
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_kind  = MK_DESC;
        mem_addr  = 64'd0;
        mem_len   = 32'd0;
        mem_wdata = q.lpib;
        case (q.st)
            ST_LOAD: begin
                mem_req  = 1'b1;
                mem_addr = bdl_base + {{(60 - IDXW){1'b0}}, q.lidx, 4'b0000};
                mem_len  = 32'd16;
            end
            ST_MOVE: begin
                mem_req  = (q.left != 32'd0) && (chunk != 32'd0);
                mem_we   = !IS_OUT;
                mem_kind = MK_DATA;
                mem_addr = cur.addr + {32'd0, q.bp};
                mem_len  = chunk;
            end
            ST_POSN: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_kind = MK_POS;
                mem_addr = {pos_base[63:1], 1'b0} + POS_OFS;
                mem_len  = 32'd4;
            end
            default: ;
        endcase
    end

    assign xfer_done = q.done;
    assign xfer_err  = q.err;
    assign link_pos  = q.lpib;
    assign entry_idx = q.be;
    assign irq       = ctl_word[CB_CMP] && ctl_word[CB_IEN];

    assert_chunk_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_kind == MK_DATA) |-> (mem_len != 32'd0 && mem_len <= cbl - link_pos));

    assert_link_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_MOVE && cbl != 32'd0) |-> (link_pos < cbl));

    assert_entry_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE && q.st != ST_LOAD) |-> (q.be <= q.last));

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !ctl_wr_en) |=> (mem_req && $stable(mem_addr) && $stable(mem_len)));

    assert_one_reply_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_done && xfer_err));

    assert_pos_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_kind == MK_POS) |-> (mem_we && mem_addr[2:0] == 3'b000));

endmodule

// File: tb/sdma_stream_engine_test.sv
module sdma_stream_engine_test;

    typedef struct packed {
        logic [15:0] bytes;
        logic [2:0]  nb;
        logic [15:0] a0, a1, a2, a3;
        logic [15:0] l0, l1, l2, l3;
        logic [31:0] lpib;
        logic [2:0]  be;
        logic        ioc;
    } vec_t;

    // cbl = 300; descriptors 0x1000/100, 0x2000/120 (interrupt), 0x3000/80
    localparam vec_t TBL [5] = '{
        '{16'd40,  3'd1, 16'h1000, 16'h0,    16'h0,    16'h0,    16'd40,  16'd0,   16'd0,  16'd0,  32'd40,  3'd0, 1'b0},
        '{16'd70,  3'd2, 16'h1028, 16'h2000, 16'h0,    16'h0,    16'd60,  16'd10,  16'd0,  16'd0,  32'd110, 3'd1, 1'b0},
        '{16'd150, 3'd2, 16'h200A, 16'h3000, 16'h0,    16'h0,    16'd110, 16'd40,  16'd0,  16'd0,  32'd260, 3'd2, 1'b1},
        '{16'd60,  3'd2, 16'h3028, 16'h1000, 16'h0,    16'h0,    16'd40,  16'd20,  16'd0,  16'd0,  32'd20,  3'd0, 1'b0},
        '{16'd300, 3'd4, 16'h1014, 16'h2000, 16'h3000, 16'h1000, 16'd80,  16'd120, 16'd80, 16'd20, 32'd20,  3'd0, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ctl_wr_en = 1'b0;
    logic [31:0]  ctl_wr_data = '0;
    logic [31:0]  ctl_word;
    logic [31:0]  cbl = 32'd300;
    logic [7:0]   lvi = 8'd2;
    logic [63:0]  bdl_base = 64'h4000;
    logic [63:0]  pos_base = 64'h8001;
    logic         xfer_valid = 1'b0;
    logic         xfer_ready;
    logic [3:0]   xfer_tag = '0;
    logic         xfer_out = 1'b0;
    logic [15:0]  xfer_bytes = '0;
    logic         xfer_done, xfer_err;
    logic         mem_req, mem_we;
    logic [1:0]   mem_kind;
    logic [63:0]  mem_addr;
    logic [31:0]  mem_len, mem_wdata;
    logic         mem_ack;
    logic [127:0] mem_rdata;
    logic [31:0]  link_pos;
    logic [2:0]   entry_idx;
    logic         irq;

    int checks = 0;
    int errors = 0;

    sdma_stream_engine uut (.*);

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else        mem_ack <= mem_req && !mem_ack;
    end

    always_comb begin
        case (mem_addr)
            64'h4000: mem_rdata = {32'h0, 32'd100, 64'h1000};
            64'h4010: mem_rdata = {32'h1, 32'd120, 64'h2000};
            64'h4020: mem_rdata = {32'h0, 32'd80,  64'h3000};
            default:  mem_rdata = '0;
        endcase
    end

    int          nb_tot = 0, npos = 0, ndesc = 0;
    logic [63:0] b_addr [64];
    logic [31:0] b_len  [64];
    logic        b_we   [64];
    logic [63:0] d_addr [64];
    logic [63:0] pos_addr = '0;
    logic [31:0] pos_data = '0;

    always @(negedge clk) begin
        if (rst_n && mem_req && mem_ack) begin
            if (mem_kind == 2'd1) begin
                b_addr[nb_tot % 64] <= mem_addr;
                b_len[nb_tot % 64]  <= mem_len;
                b_we[nb_tot % 64]   <= mem_we;
                nb_tot <= nb_tot + 1;
            end else if (mem_kind == 2'd2) begin
                pos_addr <= mem_addr;
                pos_data <= mem_wdata;
                npos <= npos + 1;
            end else begin
                d_addr[ndesc % 64] <= mem_addr;
                ndesc <= ndesc + 1;
            end
        end
    end

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [31:0] v);
        @(negedge clk);
        ctl_wr_en = 1'b1;
        ctl_wr_data = v;
        @(negedge clk);
        ctl_wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_req(input logic [3:0] tag, input logic dir, input logic [15:0] n,
                          output logic gd, output logic ge);
        gd = 1'b0;
        ge = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 400 && !xfer_ready; i++) @(negedge clk);
        xfer_valid = 1'b1;
        xfer_tag = tag;
        xfer_out = dir;
        xfer_bytes = n;
        @(negedge clk);
        xfer_valid = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (xfer_done || xfer_err) begin
                gd = xfer_done;
                ge = xfer_err;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    function automatic logic [15:0] slot_a(vec_t v, int k);
        case (k)
            0: return v.a0;
            1: return v.a1;
            2: return v.a2;
            default: return v.a3;
        endcase
    endfunction

    function automatic logic [15:0] slot_l(vec_t v, int k);
        case (k)
            0: return v.l0;
            1: return v.l1;
            2: return v.l2;
            default: return v.l3;
        endcase
    endfunction

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic gd, ge;
        int nb0, np0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check("R1 control word", ctl_word, 64'h2000_0000);
        check("R1 link position", link_pos, 0);
        check("R1 entry index", entry_idx, 0);
        check("R1 no request", mem_req, 0);
        check("R1 ready", xfer_ready, 1);
        check("R1 irq", irq, 0);

        do_req(4'd3, 1'b1, 16'd40, gd, ge);
        check("R12 refused before run", ge, 1);

        wr_ctl(32'h0030_0006);
        repeat (12) @(negedge clk);
        check("R2 fetch count", ndesc, 3);
        check("R2 fetch 0", d_addr[0], 64'h4000);
        check("R2 fetch 1", d_addr[1], 64'h4010);
        check("R2 fetch 2", d_addr[2], 64'h4020);
        check("R2 control word", ctl_word, 64'h2030_0006);

        nb0 = nb_tot;
        do_req(4'd4, 1'b1, 16'd40, gd, ge);
        check("R3 wrong tag err", ge, 1);
        do_req(4'd3, 1'b0, 16'd40, gd, ge);
        check("R3 wrong direction err", ge, 1);
        check("R3 no bursts on refusal", nb_tot - nb0, 0);

        for (int v = 0; v < 5; v++) begin
            wr_ctl(32'h0430_0006);
            nb0 = nb_tot;
            np0 = npos;
            do_req(4'd3, 1'b1, TBL[v].bytes, gd, ge);
            check("R11 done", gd, 1);
            check("R4 burst count", nb_tot - nb0, TBL[v].nb);
            for (int k = 0; k < 4; k++) begin
                if (k < int'(TBL[v].nb)) begin
                    check("R4 burst addr", b_addr[(nb0 + k) % 64], 64'(slot_a(TBL[v], k)));
                    check("R4 burst len", b_len[(nb0 + k) % 64], 64'(slot_l(TBL[v], k)));
                    check("R4 playback reads", b_we[(nb0 + k) % 64], 0);
                end
            end
            check("R5 link position", link_pos, TBL[v].lpib);
            check("R6 entry index", entry_idx, TBL[v].be);
            check("R7 completion bit", ctl_word[26], TBL[v].ioc);
            check("R7 irq", irq, TBL[v].ioc);
            check("R9 position write count", npos - np0, 1);
            check("R9 position addr", pos_addr, 64'h8028);
            check("R9 position data", pos_data, TBL[v].lpib);
        end

        wr_ctl(32'h0430_0006);
        check("R8 w1c clears bit 26", ctl_word[26], 0);
        check("R8 irq low", irq, 0);
        check("R8 other bits kept", ctl_word, 64'h2030_0006);

        nb0 = nb_tot;
        do_req(4'd3, 1'b1, 16'd0, gd, ge);
        check("R11 zero-byte done", gd, 1);
        check("R11 zero-byte no bursts", nb_tot - nb0, 0);

        pos_base = 64'h8000;
        nb0 = nb_tot;
        np0 = npos;
        do_req(4'd3, 1'b1, 16'd10, gd, ge);
        check("R9 disabled done", gd, 1);
        check("R9 no position write", npos - np0, 0);
        check("R4 burst addr cont", b_addr[nb0 % 64], 64'h1014);
        check("R5 link after", link_pos, 30);

        wr_ctl(32'h0030_0004);
        do_req(4'd3, 1'b1, 16'd10, gd, ge);
        check("R12 refused after run clear", ge, 1);

        wr_ctl(32'h0030_0006);
        repeat (12) @(negedge clk);
        check("R2 restart link reset", link_pos, 0);
        check("R2 restart entry reset", entry_idx, 0);
        nb0 = nb_tot;
        do_req(4'd3, 1'b1, 16'd40, gd, ge);
        check("R2 restart burst addr", b_addr[nb0 % 64], 64'h1000);

        wr_ctl(32'h0000_0001);
        check("R10 reset word", ctl_word, 64'h2000_0000);
        do_req(4'd3, 1'b1, 16'd10, gd, ge);
        check("R10 refused after stream reset", ge, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule